// File: doc/BRIEF.md
# Serial Converter Port Controller

This block is the digital side of a four-wire serial link into a 10-bit converter. A host lowers chip select and then sends 10 to 16 serial clocks. The first four rising edges carry a channel address, most significant bit first. On the same clocks the falling edges shift out the result of the previous conversion, most significant bit first. After the tenth falling edge the data line reads zero. On that same edge the block hands the captured address to an external conversion sequencer and drops its end-of-conversion flag.

The serial pins are sampled by a faster system clock. Chip select is accepted only after it has stayed at a new level for a programmable settle time, so short glitches are filtered out. When the host keeps chip select low between frames, the next frame starts by itself. In the short and long fast frames it starts when the result arrives. In the long slow frame it starts at the sixteenth falling edge. A fresh chip-select activation while a conversion runs aborts that conversion.

Top module: `serlink_adc_port`

## Requirements
- R1: After reset, `dout_oe` is 0, `eoc` is 1, and `conv_start` and `conv_abort` are 0. The result register holds zero, so the first frame reads ten zero bits.
- R2: After the two-flop synchronizer, a `cs_n` level takes effect only once it has held for `CS_SETTLE` system cycles. A pulse of two system cycles in either direction leaves `dout_oe` and the frame state unchanged.
- R3: While the filtered chip select is inactive (high), `dout_oe` is 0. Serial clock and address activity is ignored: no edge is counted and no conversion starts.
- R4: When chip select becomes active, `dout` shows bit 9 of the result register. Each following serial-clock falling edge shows the next lower bit, so bit 0 appears after the ninth falling edge.
- R5: The address is taken from `addr_in` on the first four serial-clock rising edges, first bit into bit 3 of `conv_addr`. Later address levels in the frame are ignored. `conv_addr` holds that address from the start pulse on.
- R6: On the tenth falling edge, `conv_start` pulses for one system cycle, `eoc` goes low and `dout` goes low. `dout` stays low for falling edges 11 to 16.
- R7: A `conv_done` pulse while a conversion runs loads `conv_result` into the result register and sets `eoc` high.
- R8: With chip select held low, a result that arrives after exactly 10 or exactly 16 falling edges is presented at once: `dout` shows its bit 9 and a new frame begins with its counters cleared.
- R9: With chip select held low, a result that arrives after falling edges 11 to 15 raises `eoc` but keeps `dout` low. Its bit 9 appears after the sixteenth falling edge, which begins the next frame.
- R10: A chip-select activation while a conversion runs pulses `conv_abort`, sets `eoc` high and leaves the result register unchanged. A later `conv_done` is ignored.
- R11: A chip-select activation in the middle of a frame clears the edge counters, so the next frame captures a fresh address and restarts from bit 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| sclk | input | 1 | Serial clock from host, asynchronous |
| addr_in | input | 1 | Serial channel address |
| dout | output | 1 | Serial data value |
| dout_oe | output | 1 | Output enable of the serial data pin (0 = high impedance) |
| eoc | output | 1 | End of conversion, high when idle or result ready |
| conv_start | output | 1 | One-cycle request to the conversion sequencer |
| conv_addr | output | ADDR_W | Channel address for the requested conversion |
| conv_abort | output | 1 | One-cycle cancel of the running conversion |
| conv_done | input | 1 | One-cycle pulse: conversion result valid |
| conv_result | input | DATA_W | Conversion result |

## Verification
A wrong edge count shows up within one serial clock as a misplaced bit on `dout` or a start pulse on the wrong falling edge. A stale or lost result register shows up in the first bit of the next frame. A wrong busy or pending flag shows up as `eoc` at the wrong level, or as the next most significant bit appearing too early or too late relative to the tenth or sixteenth falling edge. A filter that passes a glitch drops `dout_oe` or pulses `conv_abort` within a few system cycles of that glitch.

// File: rtl/serlink_pkg.sv
package serlink_pkg;
    localparam int ADDR_W    = 4;
    localparam int DATA_W    = 10;
    localparam int FRAME_MAX = 16;

    typedef struct packed {
        logic zero;
        logic busy;
        logic pending;
    } frame_flags_t;

    function automatic int cnt_width(input int max_val);
        return $clog2(max_val + 1);
    endfunction
endpackage

// File: rtl/serlink_sync.sv
module serlink_sync #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= {STAGES{RST_VAL[g]}};
            else     chain <= {chain[STAGES-2:0], d[g]};
        end
        assign q[g] = chain[STAGES-1];
    end
endmodule

// File: rtl/serlink_cs_filter.sv
module serlink_cs_filter #(
    parameter int SETTLE = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_n_sync,
    output logic cs_act,
    output logic act_evt
);
    localparam int           CW   = serlink_pkg::cnt_width(SETTLE);
    localparam logic [CW-1:0] LAST = CW'(SETTLE - 1);

    logic          cs_n_q;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_n_q  <= 1'b1;
            cnt     <= '0;
            act_evt <= 1'b0;
        end else begin
            act_evt <= 1'b0;
            if (cs_n_sync == cs_n_q) begin
                cnt <= '0;
            end else if (cnt == LAST) begin
                cs_n_q  <= cs_n_sync;
                cnt     <= '0;
                act_evt <= ~cs_n_sync;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign cs_act = ~cs_n_q;
endmodule

// File: rtl/serlink_frame_ctrl.sv
module serlink_frame_ctrl
    import serlink_pkg::*;
#(
    parameter int DATA_W    = serlink_pkg::DATA_W,
    parameter int ADDR_W    = serlink_pkg::ADDR_W,
    parameter int FRAME_MAX = serlink_pkg::FRAME_MAX
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_act,
    input  logic              cs_act_evt,
    input  logic              sclk_s,
    input  logic              addr_s,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_result,
    output logic              dout,
    output logic              dout_oe,
    output logic              eoc,
    output logic              conv_start,
    output logic              conv_abort,
    output logic [ADDR_W-1:0] conv_addr
);
    localparam int            FW       = cnt_width(FRAME_MAX);
    localparam int            RW       = cnt_width(ADDR_W);
    localparam logic [FW-1:0] START_AT = FW'(DATA_W);
    localparam logic [FW-1:0] FULL_AT  = FW'(FRAME_MAX);
    localparam logic [RW-1:0] RISE_AT  = RW'(ADDR_W);

    logic              sclk_prev;
    logic [FW-1:0]     falls;
    logic [FW-1:0]     falls_inc;
    logic [RW-1:0]     rises;
    logic [ADDR_W-1:0] addr_sh;
    logic [DATA_W-1:0] shreg;
    logic [DATA_W-1:0] out_reg;
    frame_flags_t      fl;
    logic              rise, fall;

    assign rise      = cs_act &  sclk_s & ~sclk_prev;
    assign fall      = cs_act & ~sclk_s &  sclk_prev;
    assign falls_inc = falls + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_prev  <= 1'b0;
            falls      <= '0;
            rises      <= '0;
            addr_sh    <= '0;
            shreg      <= '0;
            out_reg    <= '0;
            fl         <= '0;
            conv_start <= 1'b0;
            conv_abort <= 1'b0;
            conv_addr  <= '0;
        end else begin
            conv_start <= 1'b0;
            conv_abort <= 1'b0;
            sclk_prev  <= sclk_s;
            if (cs_act_evt) begin
                falls      <= '0;
                rises      <= '0;
                shreg      <= out_reg;
                fl.zero    <= 1'b0;
                fl.pending <= 1'b0;
                if (fl.busy) begin
                    fl.busy    <= 1'b0;
                    conv_abort <= 1'b1;
                end
            end else begin
                if (rise && rises < RISE_AT) begin
                    addr_sh <= {addr_sh[ADDR_W-2:0], addr_s};
                    rises   <= rises + 1'b1;
                end
                if (fall && falls < FULL_AT) begin
                    falls <= falls_inc;
                    if (falls_inc < START_AT)
                        shreg <= shreg << 1;
                    if (falls_inc == START_AT) begin
                        fl.zero    <= 1'b1;
                        fl.busy    <= 1'b1;
                        conv_start <= 1'b1;
                        conv_addr  <= addr_sh;
                    end
                    if (falls_inc == FULL_AT && fl.pending) begin
                        falls      <= '0;
                        rises      <= '0;
                        shreg      <= out_reg;
                        fl.zero    <= 1'b0;
                        fl.pending <= 1'b0;
                    end
                end
                if (conv_done && fl.busy) begin
                    out_reg <= conv_result;
                    fl.busy <= 1'b0;
                    if (cs_act) begin
                        if (falls == START_AT || falls == FULL_AT) begin
                            falls   <= '0;
                            rises   <= '0;
                            shreg   <= conv_result;
                            fl.zero <= 1'b0;
                        end else begin
                            fl.pending <= 1'b1;
                        end
                    end
                end
            end
        end
    end

    assign dout    = fl.zero ? 1'b0 : shreg[DATA_W-1];
    assign dout_oe = cs_act;
    assign eoc     = ~fl.busy;
endmodule

// File: rtl/serlink_adc_port.sv
module serlink_adc_port #(
    parameter int DATA_W      = serlink_pkg::DATA_W,
    parameter int ADDR_W      = serlink_pkg::ADDR_W,
    parameter int FRAME_MAX   = serlink_pkg::FRAME_MAX,
    parameter int CS_SETTLE   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              addr_in,
    output logic              dout,
    output logic              dout_oe,
    output logic              eoc,
    output logic              conv_start,
    output logic [ADDR_W-1:0] conv_addr,
    output logic              conv_abort,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_result
);
    logic [1:0] ser_sync;
    logic       cs_n_sync;
    logic       cs_act;
    logic       cs_act_evt;

    serlink_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) u_ser_sync (
        .clk (clk),
        .rst (rst),
        .d   ({sclk, addr_in}),
        .q   (ser_sync)
    );

    serlink_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
        .clk (clk),
        .rst (rst),
        .d   (cs_n),
        .q   (cs_n_sync)
    );

    serlink_cs_filter #(.SETTLE(CS_SETTLE)) u_cs_filter (
        .clk       (clk),
        .rst       (rst),
        .cs_n_sync (cs_n_sync),
        .cs_act    (cs_act),
        .act_evt   (cs_act_evt)
    );

    serlink_frame_ctrl #(
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W),
        .FRAME_MAX (FRAME_MAX)
    ) u_frame (
        .clk         (clk),
        .rst         (rst),
        .cs_act      (cs_act),
        .cs_act_evt  (cs_act_evt),
        .sclk_s      (ser_sync[1]),
        .addr_s      (ser_sync[0]),
        .conv_done   (conv_done),
        .conv_result (conv_result),
        .dout        (dout),
        .dout_oe     (dout_oe),
        .eoc         (eoc),
        .conv_start  (conv_start),
        .conv_abort  (conv_abort),
        .conv_addr   (conv_addr)
    );
endmodule

// File: rtl/serlink_adc_port_chk.sv
module serlink_adc_port_chk (
    input logic clk,
    input logic rst,
    input logic cs_n,
    input logic dout,
    input logic dout_oe,
    input logic eoc,
    input logic conv_start,
    input logic conv_abort,
    input logic conv_done
);
    p_start_drops_eoc_r6: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> (!eoc && !dout));

    p_start_single_r6: assert property (@(posedge clk) disable iff (rst)
        conv_start |=> !conv_start);

    p_done_raises_eoc_r7: assert property (@(posedge clk) disable iff (rst)
        (conv_done && !eoc) |=> eoc);

    p_abort_frees_eoc_r10: assert property (@(posedge clk) disable iff (rst)
        conv_abort |-> eoc);

    p_oe_on_settled_low_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(dout_oe) |-> (!$past(cs_n) && !$past(cs_n, 2)));

    p_oe_off_settled_high_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(dout_oe) |-> ($past(cs_n) && $past(cs_n, 2)));

    p_start_abort_excl_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({conv_start, conv_abort}));
endmodule

bind serlink_adc_port serlink_adc_port_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cs_n       (cs_n),
    .dout       (dout),
    .dout_oe    (dout_oe),
    .eoc        (eoc),
    .conv_start (conv_start),
    .conv_abort (conv_abort),
    .conv_done  (conv_done)
);

// File: tb/serlink_adc_port_tb_top.sv
module serlink_adc_port_tb_top;
    localparam int H = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1;
    logic       sclk = 1'b0;
    logic       addr_in = 1'b0;
    logic       conv_done = 1'b0;
    logic [9:0] conv_result = '0;
    logic       dout, dout_oe, eoc, conv_start, conv_abort;
    logic [3:0] conv_addr;

    always #2 clk = ~clk;

    serlink_adc_port dut_i (
        .clk (clk), .rst (rst), .cs_n (cs_n), .sclk (sclk), .addr_in (addr_in),
        .dout (dout), .dout_oe (dout_oe), .eoc (eoc), .conv_start (conv_start),
        .conv_addr (conv_addr), .conv_abort (conv_abort), .conv_done (conv_done),
        .conv_result (conv_result)
    );

    int         checks = 0;
    int         fails = 0;
    int         starts = 0;
    int         aborts = 0;
    logic [3:0] last_addr = '0;
    logic [9:0] model = '0;
    bit         finished = 0;

    always @(negedge clk) begin
        if (!rst && conv_start) begin
            starts++;
            last_addr = conv_addr;
        end
        if (!rst && conv_abort) aborts++;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_sys(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cs_set(input logic v);
        cs_n = v;
        wait_sys(12);
    endtask

    task automatic pulse_done(input logic [9:0] v);
        conv_result = v;
        conv_done   = 1'b1;
        wait_sys(1);
        conv_done   = 1'b0;
        wait_sys(4);
    endtask

    task automatic run_frame(input logic [3:0] a, input int n, input logic [9:0] word,
                             input int done_at, input logic [9:0] nres);
        int s0;
        s0 = starts;
        for (int i = 1; i <= n; i++) begin
            addr_in = (i <= 4) ? a[4-i] : logic'(i % 2);
            wait_sys(H);
            sclk = 1'b1;
            wait_sys(H);
            if (i <= 10) chk("R4 data bit", dout, word[10-i]);
            else         chk("R6 tail zero", dout, 0);
            sclk = 1'b0;
            wait_sys(H);
            if (i == 10) begin
                chk("R6 eoc low", eoc, 0);
                chk("R6 one start", starts, s0 + 1);
                chk("R6 dout low", dout, 0);
                chk("R5 address", last_addr, a);
            end
            if (i == done_at) begin
                pulse_done(nres);
                model = nres;
                chk("R7 eoc high", eoc, 1);
                chk("R9 held low", dout, 0);
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int okcnt;
        wait_sys(5);
        rst = 1'b0;
        wait_sys(3);
        // R1: reset state
        chk("R1 oe", dout_oe, 0);
        chk("R1 eoc", eoc, 1);
        chk("R1 start", starts, 0);

        // R3: serial activity ignored while chip select high
        for (int i = 0; i < 12; i++) begin
            addr_in = logic'(i % 2);
            wait_sys(H); sclk = 1'b1; wait_sys(H); sclk = 1'b0;
        end
        wait_sys(H);
        chk("R3 oe off", dout_oe, 0);
        chk("R3 no start", starts, 0);

        // R1/R4: first frame reads zeros
        cs_set(1'b0);
        chk("R4 oe on", dout_oe, 1);
        chk("R1 first msb", dout, model[9]);
        run_frame(4'h5, 10, model, 0, '0);
        cs_set(1'b1);
        chk("R3 oe off after frame", dout_oe, 0);
        pulse_done(10'h2A5);
        model = 10'h2A5;
        chk("R7 eoc after done", eoc, 1);

        // R4/R6: 16-clock frame with chip select toggled
        cs_set(1'b0);
        chk("R4 msb on select", dout, model[9]);
        run_frame(4'hA, 16, model, 0, '0);
        cs_set(1'b1);
        pulse_done(10'h15C);
        model = 10'h15C;

        // R8: chip select held low, 10-clock fast frame
        cs_set(1'b0);
        run_frame(4'h3, 10, model, 0, '0);
        pulse_done(10'h3C1);
        model = 10'h3C1;
        chk("R8 msb at done (10)", dout, model[9]);
        chk("R8 eoc", eoc, 1);
        run_frame(4'h7, 16, model, 0, '0);
        chk("R8 waiting low", dout, 0);
        pulse_done(10'h2F0);
        model = 10'h2F0;
        chk("R8 msb at done (16)", dout, model[9]);

        // R9: slow frame, result ready after 12th fall
        run_frame(4'hC, 16, model, 12, 10'h3B6);
        chk("R9 msb after 16th", dout, model[9]);
        run_frame(4'h1, 10, model, 0, '0);
        pulse_done(10'h2AA);
        model = 10'h2AA;
        chk("R8 msb again", dout, model[9]);

        // R2: short glitch high while active
        cs_n = 1'b1; wait_sys(2); cs_n = 1'b0;
        okcnt = 0;
        for (int i = 0; i < 14; i++) begin
            wait_sys(1);
            if (dout_oe) okcnt++;
        end
        chk("R2 glitch high ignored", okcnt, 14);
        chk("R2 data kept", dout, model[9]);
        cs_set(1'b1);
        chk("R2 settled high", dout_oe, 0);
        cs_n = 1'b0; wait_sys(2); cs_n = 1'b1;
        okcnt = 0;
        for (int i = 0; i < 14; i++) begin
            wait_sys(1);
            if (!dout_oe) okcnt++;
        end
        chk("R2 glitch low ignored", okcnt, 14);
        chk("R2 no abort", aborts, 0);

        // R10: abort during conversion
        cs_set(1'b0);
        run_frame(4'h9, 10, model, 0, '0);
        cs_set(1'b1);
        cs_set(1'b0);
        chk("R10 abort pulse", aborts, 1);
        chk("R10 eoc high", eoc, 1);
        chk("R10 result kept", dout, model[9]);
        pulse_done(10'h111);
        chk("R10 stray done", eoc, 1);
        run_frame(4'h2, 10, model, 0, '0);
        cs_set(1'b1);
        pulse_done(10'h155);
        model = 10'h155;

        // R11: reselect in the middle of the address phase
        cs_set(1'b0);
        for (int i = 1; i <= 2; i++) begin
            addr_in = 1'b1;
            wait_sys(H); sclk = 1'b1; wait_sys(H);
            chk("R11 early bit", dout, model[10-i]);
            sclk = 1'b0; wait_sys(H);
        end
        cs_set(1'b1);
        cs_set(1'b0);
        chk("R11 restart msb", dout, model[9]);
        chk("R11 no abort when idle", aborts, 1);
        run_frame(4'hB, 10, model, 0, '0);
        pulse_done(10'h0F0);
        cs_set(1'b1);

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule